// File: doc/BRIEF.md
# Radix-2 Booth Signed Multiplier Datapath

This block holds the working registers of a 13 by 13 bit signed multiplier that uses radix-2 Booth recoding. It has an accumulator, a shift register for the multiplier, a register for the multiplicand, a one-bit recoding history flag and a one-bit sign flag. It also has a single adder that can add or subtract. An external sequencer drives three plain strobes. `init` starts a product. `ex_op` marks an operate step. `shift` marks a shift step. After thirteen operate/shift iterations, the signed 26-bit product appears on `product`, with the accumulator as the upper half and the multiplier register as the lower half.

The operands are captured only on `init`. The block has no handshake: it obeys the strobes in every cycle, and it cannot apply back-pressure. The source of the operands must hold `mcand_in` and `mplier_in` steady in the cycle where `init` is high. The consumer samples `product` once the sequencer reports that the product is complete. On every operate step the adder computes both candidate results. A result is written to the accumulator only when the multiplier LSB differs from the history flag. A sign flag keeps the true 14-bit sign of the accumulator, so the most-negative operand cases do not overflow.

Top module: `booth_mul13_datapath`

## Requirements
- R1: On a cycle with `init` high, the following happen at the next edge: the multiplicand register loads `mcand_in`, the multiplier register loads `mplier_in`, and the accumulator, history flag and sign flag clear to 0. As a result, `product` becomes `{13'd0, mplier_in}`.
- R2: On an operate step where the multiplier LSB is 0 and the history flag is 1, the accumulator becomes accumulator plus multiplicand (mod 2^13).
- R3: On an operate step where the multiplier LSB is 1 and the history flag is 0, the accumulator becomes accumulator minus multiplicand (mod 2^13).
- R4: On an operate step where the multiplier LSB equals the history flag, the accumulator keeps its value.
- R5: On a shift step, the accumulator and the multiplier register shift right together as one 26-bit value. The accumulator LSB enters the multiplier MSB. The multiplier LSB enters the history flag. The accumulator MSB receives the true sign of the accumulator, taken from its 14-bit sign-extended value, so that a result of +4096 shifts to +2048.
- R6: In a cycle with no strobe high, all state and `product` stay unchanged.
- R7: `init` takes priority over `ex_op` and `shift` in the same cycle. Those two strobes then have no effect.
- R8: When `ex_op` and `shift` are both high without `init`, the operate step is applied first and its result is then shifted, in one cycle. Thirteen such cycles after `init` give the same product as thirteen separate operate/shift pairs.
- R9: After `init` and then thirteen operate/shift iterations, `product` equals the signed product of the two operands as a 26-bit two's-complement value, for every operand pair, including -4096 times -4096.
- R10: A synchronous active-high `rst` clears all state, so `product` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| init | input | 1 | Start strobe: captures operands, clears accumulator and flags |
| ex_op | input | 1 | Operate strobe: conditional add or subtract into the accumulator |
| shift | input | 1 | Shift strobe: arithmetic right shift of accumulator and multiplier |
| mcand_in | input | 13 | Signed multiplicand operand |
| mplier_in | input | 13 | Signed multiplier operand |
| product | output | 26 | Accumulator (upper half) concatenated with multiplier register (lower half) |

## Verification
Two functions can land in the same cycle: the conditional accumulator update and the arithmetic shift. When both strobes are high, the shift has to see the freshly computed accumulator and sign, not the stored ones. The bench provokes this by running whole products with both strobes high for thirteen cycles. It judges the result against the reference signed product, and the same operand pairs are also run with the two steps in separate cycles. A second overlap, `init` arriving together with both step strobes, is judged by checking that `product` shows only the freshly loaded operands.

// File: rtl/booth_dp_pkg.sv
package booth_dp_pkg;

  // What an operate step does to the accumulator
  typedef enum logic [1:0] {
    ACT_KEEP = 2'd0,
    ACT_ADD  = 2'd1,
    ACT_SUB  = 2'd2
  } acc_act_e;

  // Radix-2 recoding of (current multiplier LSB, previous LSB)
  function automatic acc_act_e recode_pair(input logic cur_bit, input logic prev_bit);
    acc_act_e r;
    case ({cur_bit, prev_bit})
      2'b01:   r = ACT_ADD;
      2'b10:   r = ACT_SUB;
      default: r = ACT_KEEP;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/booth_recoder.sv
module booth_recoder
  import booth_dp_pkg::*;
(
  input  logic     op_en,
  input  logic     cur_bit,
  input  logic     prev_bit,
  output acc_act_e act,
  output logic     commit,
  output logic     subtract
);

  always_comb begin
    act      = op_en ? recode_pair(cur_bit, prev_bit) : ACT_KEEP;
    commit   = (act != ACT_KEEP);
    subtract = cur_bit;
  end

  // R3: a committed step subtracts exactly when recoding asks for subtraction
  always_comb begin
    if (commit) begin
      recode_sub_chk: assert ((act == ACT_SUB) == subtract);
    end
  end

endmodule

// File: rtl/booth_addsub.sv
module booth_addsub #(
  parameter int W = 13
) (
  input  logic [W-1:0] acc_val,
  input  logic [W-1:0] mcand,
  input  logic         sub,
  output logic [W-1:0] result,
  output logic         true_sign
);

  localparam int EW = W + 1;

  logic [EW-1:0] ext_a;
  logic [EW-1:0] ext_b;
  logic [EW-1:0] total;

  always_comb begin
    ext_a     = {acc_val[W-1], acc_val};
    ext_b     = {mcand[W-1], mcand} ^ {EW{sub}};
    total     = ext_a + ext_b + EW'(sub);
    result    = total[W-1:0];
    true_sign = total[EW-1];
  end

endmodule

// File: rtl/booth_shreg.sv
module booth_shreg #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift,
  input  logic         shift_in,
  output logic [W-1:0] q
);

  logic [W-1:0] base;
  logic [W-1:0] nxt;

  always_comb begin
    base = load ? load_val : q;
    nxt  = shift ? {shift_in, base[W-1:1]} : base;
  end

  always_ff @(posedge clk) begin
    if (rst)               q <= '0;
    else if (clr)          q <= '0;
    else if (load || shift) q <= nxt;
  end

  // R1
  clr_zero_chk: assert property (@(posedge clk) disable iff (rst)
    clr |=> (q == '0));

  // R5
  shift_only_chk: assert property (@(posedge clk) disable iff (rst)
    (shift && !clr && !load) |=> (q == {$past(shift_in), $past(q[W-1:1])}));

  // R6
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!clr && !load && !shift) |=> $stable(q));

endmodule

// File: rtl/booth_mul13_datapath.sv
module booth_mul13_datapath
  import booth_dp_pkg::*;
#(
  parameter int W = 13
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           init,
  input  logic           ex_op,
  input  logic           shift,
  input  logic [W-1:0]   mcand_in,
  input  logic [W-1:0]   mplier_in,
  output logic [2*W-1:0] product
);

  localparam int PW = 2 * W;

  logic [W-1:0] mcand_q;
  logic [W-1:0] acc;
  logic [W-1:0] mq;
  logic         hist_f;
  logic         sign_f;

  logic         op_eff;
  logic         sh_eff;
  acc_act_e     act;
  logic         commit;
  logic         subtract;
  logic [W-1:0] sum;
  logic         sum_sign;
  logic [W-1:0] acc_pre;
  logic         sign_pre;

  // init overrides the step strobes (R7)
  assign op_eff = ex_op & ~init;
  assign sh_eff = shift & ~init;

  booth_recoder u_recoder (
    .op_en    (op_eff),
    .cur_bit  (mq[0]),
    .prev_bit (hist_f),
    .act      (act),
    .commit   (commit),
    .subtract (subtract)
  );

  booth_addsub #(.W(W)) u_addsub (
    .acc_val   (acc),
    .mcand     (mcand_q),
    .sub       (subtract),
    .result    (sum),
    .true_sign (sum_sign)
  );

  // Accumulator and sign as seen after the operate half of a cycle
  always_comb begin
    acc_pre  = commit ? sum : acc;
    if (op_eff) sign_pre = commit ? sum_sign : acc[W-1];
    else        sign_pre = sign_f;
  end

  booth_shreg #(.W(W)) u_acc (
    .clk      (clk),
    .rst      (rst),
    .clr      (init),
    .load     (commit),
    .load_val (sum),
    .shift    (sh_eff),
    .shift_in (sign_pre),
    .q        (acc)
  );

  booth_shreg #(.W(W)) u_mq (
    .clk      (clk),
    .rst      (rst),
    .clr      (1'b0),
    .load     (init),
    .load_val (mplier_in),
    .shift    (sh_eff),
    .shift_in (acc_pre[0]),
    .q        (mq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mcand_q <= '0;
      hist_f  <= 1'b0;
      sign_f  <= 1'b0;
    end else if (init) begin
      mcand_q <= mcand_in;
      hist_f  <= 1'b0;
      sign_f  <= 1'b0;
    end else begin
      if (sh_eff) hist_f <= mq[0];
      if (op_eff || sh_eff) sign_f <= sign_pre;
    end
  end

  assign product = PW'({acc, mq});

  // R1, R7
  init_load_chk: assert property (@(posedge clk) disable iff (rst)
    init |=> (acc == '0 && mq == $past(mplier_in) && !hist_f && !sign_f));

  // R2
  add_step_chk: assert property (@(posedge clk) disable iff (rst)
    (ex_op && !shift && !init && !mq[0] && hist_f) |=>
      (acc == W'($past(acc) + $past(mcand_q))));

  // R3
  sub_step_chk: assert property (@(posedge clk) disable iff (rst)
    (ex_op && !shift && !init && mq[0] && !hist_f) |=>
      (acc == W'($past(acc) - $past(mcand_q))));

  // R4
  keep_step_chk: assert property (@(posedge clk) disable iff (rst)
    (ex_op && !shift && !init && (mq[0] == hist_f)) |=> $stable(acc));

  // R5
  hist_shift_chk: assert property (@(posedge clk) disable iff (rst)
    (shift && !init) |=> (hist_f == $past(mq[0])));

  // R6
  idle_chk: assert property (@(posedge clk) disable iff (rst)
    (!init && !ex_op && !shift) |=> ($stable(product) && $stable(hist_f)));

  // R8
  fused_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (ex_op && shift && !init && (mq[0] == hist_f)) |=>
      (acc == {$past(acc[W-1]), $past(acc[W-1:1])}));

endmodule

// File: tb/test_booth_mul13_datapath.sv
module test_booth_mul13_datapath;

  localparam int W = 13;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          init = 1'b0;
  logic          ex_op = 1'b0;
  logic          shift = 1'b0;
  logic [W-1:0]  mcand_in = '0;
  logic [W-1:0]  mplier_in = '0;
  logic [2*W-1:0] product;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  booth_mul13_datapath #(.W(W)) i_booth_mul13_datapath (
    .clk       (clk),
    .rst       (rst),
    .init      (init),
    .ex_op     (ex_op),
    .shift     (shift),
    .mcand_in  (mcand_in),
    .mplier_in (mplier_in),
    .product   (product)
  );

  task automatic check(input string tag, input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: product=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive strobes for exactly one cycle; called at a negedge, returns at the next
  task automatic step(input logic i, input logic e, input logic s);
    init = i; ex_op = e; shift = s;
    @(negedge clk);
    init = 1'b0; ex_op = 1'b0; shift = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R10 reset state", product, '0);
  endtask

  task automatic t_init_load();
    mcand_in = 13'd77; mplier_in = 13'h0ABC;
    step(1, 0, 0);
    check("R1 init load", product, {13'd0, 13'h0ABC});
  endtask

  // M=5, multiplier=1: sub, shift, add
  task automatic t_add_sub_shift();
    mcand_in = 13'd5; mplier_in = 13'd1;
    step(1, 0, 0);
    step(0, 1, 0);
    check("R3 subtract step", product, {13'h1FFB, 13'd1});
    step(0, 0, 1);
    check("R5 shift negative", product, {13'h1FFD, 13'h1000});
    step(0, 1, 0);
    check("R2 add step", product, {13'd2, 13'h1000});
  endtask

  // M=-4096, multiplier=1: subtraction gives +4096, shift must give +2048
  task automatic t_overflow_shift();
    mcand_in = 13'h1000; mplier_in = 13'd1;
    step(1, 0, 0);
    step(0, 1, 0);
    step(0, 0, 1);
    check("R5 true-sign shift", product, {13'h0800, 13'h0000});
  endtask

  task automatic t_keep_idle();
    mcand_in = 13'd9; mplier_in = 13'd2;
    step(1, 0, 0);
    step(0, 1, 0);
    check("R4 keep on equal bits", product, {13'd0, 13'd2});
    repeat (3) @(negedge clk);
    check("R6 idle hold", product, {13'd0, 13'd2});
  endtask

  task automatic t_init_priority();
    mcand_in = 13'd3; mplier_in = 13'd1;
    step(1, 0, 0);
    step(0, 1, 0);
    mcand_in = 13'd6; mplier_in = 13'd1;
    step(1, 1, 1);
    check("R7 init wins", product, {13'd0, 13'd1});
    step(0, 1, 0);
    check("R7 new multiplicand used", product, {13'h1FFA, 13'd1});
  endtask

  task automatic t_full(input int a, input int b, input bit fused);
    logic [2*W-1:0] exp;
    exp = (2*W)'(a * b);
    mcand_in = W'(a); mplier_in = W'(b);
    step(1, 0, 0);
    for (int k = 0; k < W; k++) begin
      if (fused) step(0, 1, 1);
      else begin
        step(0, 1, 0);
        step(0, 0, 1);
      end
    end
    if (fused) check($sformatf("R8 fused %0d*%0d", a, b), product, exp);
    else       check($sformatf("R9 product %0d*%0d", a, b), product, exp);
  endtask

  task automatic t_products(input bit fused);
    t_full(-4096, -4096, fused);
    t_full(-4096, 4095, fused);
    t_full(4095, -4096, fused);
    t_full(0, 1234, fused);
    t_full(1234, 0, fused);
    t_full(-1, -1, fused);
    t_full(4095, 4095, fused);
    t_full(-4096, 1, fused);
    t_full(7, -3, fused);
    t_full(-2048, 3, fused);
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: product=%h expected=run complete", product);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_init_load();
    t_add_sub_shift();
    t_overflow_shift();
    t_keep_idle();
    t_init_priority();
    t_products(1'b0);
    t_products(1'b1);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule